// File: doc/BRIEF.md
# Slot-Aligned Shared Memory Bus Controller

This controller terminates the bus cycles of a 16-bit CPU master. A shared memory sits behind it, and the CPU shares that memory in time with a display fetcher. The CPU may only use the memory in fixed four-clock slots. A free-running 2-bit phase count, `slot_phase`, marks those slots, and a slot starts where the phase is 0.

A shared-memory access whose strobe is first seen at any other phase waits until the next phase-0 edge. It then occupies the whole slot. The waits therefore depend on the live phase and not on a per-access count. A CPU sequence that releases its strobe two clocks early can land its next access at phase 0 and pay no wait at all, which saves a whole slot compared with rounding each access on its own.

Accesses to the CPU-local register window skip the slot grid entirely and complete on the register acknowledge. A watchdog covers accesses that nobody answers. It counts clocks while the strobe is held. After 64 clocks it runs one four-clock error transaction and then signals a bus error, 68 clocks after the strobe was first seen.

The controller walks through eight named states:

- **IDLE** waits for the strobe. On the strobe it moves as follows:
  - shared memory at phase 0 goes to SLOT;
  - shared memory at any other phase goes to ALIGN;
  - a local register with the acknowledge already high goes to ACK;
  - a local register without it goes to LOCAL;
  - any other address goes to VOID.
- **ALIGN** moves to SLOT at the next phase-0 edge.
- **SLOT** drives `ram_grant` and moves to ACK at the following phase-0 edge.
- **LOCAL** moves to ACK on `reg_ack`, or to FAULT when the watchdog expires.
- **VOID** moves to FAULT when the watchdog expires.
- **FAULT** runs the error transaction and moves to BERR when it ends.
- **ACK** and **BERR** hold their strobe until the master releases it.

Every state returns to IDLE on the first edge that samples the strobe low.

Top module: `phase_wait_ctrl`

## Requirements
- R1: While reset is held and directly after it, `cpu_dtack`, `cpu_berr` and `ram_grant` are low.
- R2: The shared region is every address below 0x400000. A shared access whose strobe is first sampled at an edge with `slot_phase` = 0 shows `cpu_dtack` after the 4th edge following that edge. `ram_grant` is high for exactly 4 clocks of that access.
- R3: A shared access first sampled at phase p ≠ 0 waits (4 − p) clocks before its slot. Its `cpu_dtack` appears (8 − p) edges after first sampling: 7 for phase 1, 6 for phase 2, 5 for phase 3. `ram_grant` is still high for exactly 4 clocks.
- R4: `ram_grant` only rises after an edge that sampled `slot_phase` = 0. Back-to-back accesses therefore take 4 clocks when the next strobe is first sampled at phase 0 and 6 clocks when it is first sampled at phase 2.
- R5: The local-register window is every address at or above 0xFF8000. A local access shows `cpu_dtack` after the edge that first samples `reg_ack` high, whatever the phase. It never raises `ram_grant`.
- R6: `reg_ack` has no effect on a shared-memory access: the latency stays as in R2 and R3.
- R7: An address in neither region never receives `cpu_dtack`. `cpu_berr` appears 68 edges after first sampling.
- R8: For a local access, `reg_ack` sampled at or before the 64th edge wins. Once the error transaction has begun, `reg_ack` is ignored and `cpu_berr` still appears at edge 68.
- R9: `cpu_dtack` and `cpu_berr` are never high together. Each stays high while the strobe stays high and drops on the edge after the strobe is sampled low.
- R10: Releasing the strobe before completion ends the access with no `cpu_dtack`, no `cpu_berr` and no further grant. The next access gets the full 64-clock watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_strobe | input | 1 | Address strobe from the CPU, active high, held until termination |
| cpu_addr | input | AW (24) | Byte address of the access |
| slot_phase | input | 2 | Free-running slot phase; 0 marks a slot start |
| reg_ack | input | 1 | Acknowledge from the local-register window |
| cpu_dtack | output | 1 | Data acknowledge to the CPU |
| cpu_berr | output | 1 | Bus error to the CPU |
| ram_grant | output | 1 | High during the four clocks of a granted shared-memory slot |

## Verification
The bench starts shared accesses at each of the four phases and chains accesses at phase 0 and phase 2. A controller that rounded each access alone, or that counted from the strobe instead of using the live phase, would show the wrong latency or a grant that is not 4 clocks long. It checks that local accesses complete exactly on `reg_ack` with no grant, and that `reg_ack` held high during a shared access changes nothing. A design that let the local acknowledge leak into shared accesses would finish them early. The watchdog is probed with an unmapped address, with acknowledges at edges 64 and 65, and after aborted accesses. An off-by-one timeout, a late acknowledge that is not ignored, or a counter that is not cleared on abort would each move the 68-edge bus error.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef enum logic [1:0] {
        RG_VOID   = 2'd0,
        RG_SHARED = 2'd1,
        RG_LOCAL  = 2'd2
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ALIGN = 3'd1,
        ST_SLOT  = 3'd2,
        ST_LOCAL = 3'd3,
        ST_VOID  = 3'd4,
        ST_FAULT = 3'd5,
        ST_ACK   = 3'd6,
        ST_BERR  = 3'd7
    } state_e;

    // Shared memory lies below shared_top, local registers at or above local_base.
    function automatic region_e classify(input logic [31:0] addr,
                                         input logic [31:0] shared_top,
                                         input logic [31:0] local_base);
        if (addr < shared_top)
            return RG_SHARED;
        else if (addr >= local_base)
            return RG_LOCAL;
        else
            return RG_VOID;
    endfunction

endpackage

// File: rtl/pwc_region.sv
module pwc_region #(
    parameter int unsigned AW         = 24,
    parameter int unsigned SHARED_TOP = 32'h0040_0000,
    parameter int unsigned LOCAL_BASE = 32'h00FF_8000
) (
    input  logic [AW-1:0]          addr,
    output pwc_pkg::region_e       region
);
    always_comb begin
        region = pwc_pkg::classify(32'(addr), SHARED_TOP, LOCAL_BASE);
    end
endmodule

// File: rtl/pwc_watchdog.sv
module pwc_watchdog #(
    parameter int unsigned LIMIT = 64,
    parameter int unsigned TAIL  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired,
    output logic term_done
);
    localparam int unsigned TOTAL = LIMIT + TAIL;
    localparam int unsigned CW    = $clog2(TOTAL + 1);

    logic [CW-1:0] cnt_q;

    // Counts clocks of an unanswered strobe; cleared whenever run drops.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (cnt_q != CW'(TOTAL))
            cnt_q <= cnt_q + CW'(1);
    end

    assign expired   = (cnt_q == CW'(LIMIT));
    assign term_done = (cnt_q == CW'(TOTAL));
endmodule

// File: rtl/phase_wait_ctrl.sv
module phase_wait_ctrl #(
    parameter int unsigned AW         = 24,
    parameter int unsigned SLOT_CLKS  = 4,
    parameter int unsigned WDOG_CLKS  = 64,
    parameter int unsigned SHARED_TOP = 32'h0040_0000,
    parameter int unsigned LOCAL_BASE = 32'h00FF_8000,
    localparam int unsigned PW        = $clog2(SLOT_CLKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_strobe,
    input  logic [AW-1:0] cpu_addr,
    input  logic [PW-1:0] slot_phase,
    input  logic          reg_ack,
    output logic          cpu_dtack,
    output logic          cpu_berr,
    output logic          ram_grant
);
    import pwc_pkg::*;

    state_e  state_q, state_d;
    region_e region;
    logic    on_slot;
    logic    wd_run, wd_expired, wd_term_done;

    pwc_region #(
        .AW         (AW),
        .SHARED_TOP (SHARED_TOP),
        .LOCAL_BASE (LOCAL_BASE)
    ) u_region (
        .addr   (cpu_addr),
        .region (region)
    );

    // Watchdog runs while the strobe is pending and no termination is shown.
    assign wd_run = cpu_strobe && (state_q != ST_ACK) && (state_q != ST_BERR);

    pwc_watchdog #(
        .LIMIT (WDOG_CLKS),
        .TAIL  (SLOT_CLKS)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (wd_run),
        .expired   (wd_expired),
        .term_done (wd_term_done)
    );

    assign on_slot = (slot_phase == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_strobe) begin
                    unique case (region)
                        RG_SHARED: state_d = on_slot ? ST_SLOT : ST_ALIGN;
                        RG_LOCAL:  state_d = reg_ack ? ST_ACK  : ST_LOCAL;
                        default:   state_d = ST_VOID;
                    endcase
                end
            end
            ST_ALIGN: begin
                if (!cpu_strobe)  state_d = ST_IDLE;
                else if (on_slot) state_d = ST_SLOT;
            end
            ST_SLOT: begin
                // The slot ends at the next phase-0 edge.
                if (!cpu_strobe)  state_d = ST_IDLE;
                else if (on_slot) state_d = ST_ACK;
            end
            ST_LOCAL: begin
                if (!cpu_strobe)     state_d = ST_IDLE;
                else if (reg_ack)    state_d = ST_ACK;
                else if (wd_expired) state_d = ST_FAULT;
            end
            ST_VOID: begin
                if (!cpu_strobe)     state_d = ST_IDLE;
                else if (wd_expired) state_d = ST_FAULT;
            end
            ST_FAULT: begin
                // Error transaction: acknowledges are no longer looked at.
                if (!cpu_strobe)       state_d = ST_IDLE;
                else if (wd_term_done) state_d = ST_BERR;
            end
            ST_ACK, ST_BERR: begin
                if (!cpu_strobe) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_dtack = (state_q == ST_ACK);
        cpu_berr  = (state_q == ST_BERR);
        ram_grant = (state_q == ST_SLOT);
    end

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
    parameter int unsigned AW         = 24,
    parameter int unsigned SLOT_CLKS  = 4,
    parameter int unsigned WDOG_CLKS  = 64,
    parameter int unsigned SHARED_TOP = 32'h0040_0000,
    parameter int unsigned LOCAL_BASE = 32'h00FF_8000,
    localparam int unsigned PW        = $clog2(SLOT_CLKS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_strobe,
    input logic [AW-1:0] cpu_addr,
    input logic [PW-1:0] slot_phase,
    input logic          reg_ack,
    input logic          cpu_dtack,
    input logic          cpu_berr,
    input logic          ram_grant
);
    localparam int ERR_EDGE = int'(WDOG_CLKS + SLOT_CLKS) + 1;

    int pend_q;

    // Edges of a strobe that has not been terminated yet.
    always_ff @(posedge clk) begin
        if (!rst_n || !cpu_strobe || cpu_dtack || cpu_berr)
            pend_q <= 0;
        else if (pend_q < ERR_EDGE)
            pend_q <= pend_q + 1;
    end

    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_dtack && cpu_berr));

    assert_dtack_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_dtack && cpu_strobe) |=> cpu_dtack);

    assert_berr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_berr && cpu_strobe) |=> cpu_berr);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_strobe |=> (!cpu_dtack && !cpu_berr && !ram_grant));

    assert_grant_on_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_grant) |-> ($past(slot_phase) == '0));

    assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_dtack) && !$past(ram_grant)) |-> $past(reg_ack));

    assert_void_noack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_strobe && pwc_pkg::classify(32'(cpu_addr), SHARED_TOP, LOCAL_BASE)
                       == pwc_pkg::RG_VOID) |-> !cpu_dtack);

    assert_err_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_berr) |-> (pend_q == ERR_EDGE));

endmodule

bind phase_wait_ctrl pwc_checker #(
    .AW         (AW),
    .SLOT_CLKS  (SLOT_CLKS),
    .WDOG_CLKS  (WDOG_CLKS),
    .SHARED_TOP (SHARED_TOP),
    .LOCAL_BASE (LOCAL_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_strobe (cpu_strobe),
    .cpu_addr   (cpu_addr),
    .slot_phase (slot_phase),
    .reg_ack    (reg_ack),
    .cpu_dtack  (cpu_dtack),
    .cpu_berr   (cpu_berr),
    .ram_grant  (ram_grant)
);

// File: tb/sim_phase_wait_ctrl.sv
module sim_phase_wait_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 24;
    localparam int PW   = 2;
    localparam int SLOT = 4;
    localparam int ERRL = 68;
    localparam logic [AW-1:0] A_RAM  = 24'h00_1000;
    localparam logic [AW-1:0] A_LOC  = 24'hFF_8200;
    localparam logic [AW-1:0] A_VOID = 24'h80_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_strobe = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [PW-1:0] slot_phase = '0;
    logic          reg_ack = 1'b0;
    logic          dtack, berr, grant;

    int total = 0;
    int bad   = 0;

    typedef struct {
        bit    is_err;
        int    lat;
        int    grants;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   edges = 0;
    int   grant_cnt = 0;
    bit   seen = 1'b0;

    phase_wait_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_strobe (cpu_strobe),
        .cpu_addr   (cpu_addr),
        .slot_phase (slot_phase),
        .reg_ack    (reg_ack),
        .cpu_dtack  (dtack),
        .cpu_berr   (berr),
        .ram_grant  (grant)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;
    initial forever @(posedge clk) slot_phase <= slot_phase + 2'd1;
    initial forever @(posedge clk) edges <= cpu_strobe ? edges + 1 : 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per termination and compares it.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (grant) grant_cnt++;
            if ((dtack || berr) && !seen) begin
                seen = 1'b1;
                if (sb.size() == 0) begin
                    check(1'b0, "R10", "unexpected termination", 1, 0);
                end else begin
                    e = sb.pop_front();
                    check((berr == e.is_err) && (dtack != e.is_err), e.tag,
                          "termination kind (berr)", int'(berr), int'(e.is_err));
                    check(edges - 1 == e.lat, e.tag, "latency", edges - 1, e.lat);
                    check(grant_cnt == e.grants, e.tag, "grant clocks", grant_cnt, e.grants);
                end
            end
            if (!cpu_strobe) begin
                seen = 1'b0;
                grant_cnt = 0;
            end
        end
    end

    // Driver: start at a chosen phase (-1 any), raise reg_ack at edge ack_at (-1 never).
    task automatic run_access(input logic [AW-1:0] addr, input int start_phase,
                              input int ack_at, input int hold, input bit exp_err,
                              input int exp_lat, input int exp_grants, input string tag);
        exp_t e;
        int   p;
        int   k;
        @(negedge clk);
        if (start_phase >= 0)
            while (int'(slot_phase) != start_phase) @(negedge clk);
        p = int'(slot_phase);
        cpu_addr   = addr;
        cpu_strobe = 1'b1;
        reg_ack    = (ack_at == 0);
        e.is_err = exp_err;
        e.lat    = (exp_lat < 0) ? ((SLOT - p) % SLOT) + SLOT : exp_lat;
        e.grants = exp_grants;
        e.tag    = tag;
        sb.push_back(e);
        k = 0;
        while (!(dtack || berr)) begin
            @(negedge clk);
            k++;
            if (ack_at > 0 && k == ack_at) reg_ack = 1'b1;
            if (k > 200) break;
        end
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            check(exp_err ? berr : dtack, "R9", "termination held with strobe", 0, 1);
        end
        cpu_strobe = 1'b0;
        reg_ack    = 1'b0;
        @(negedge clk);
        check(!dtack && !berr, "R9", "termination dropped after release",
              int'(dtack || berr), 0);
    endtask

    task automatic abort_access(input logic [AW-1:0] addr, input int start_phase,
                                input int after, input string tag);
        int hits;
        @(negedge clk);
        while (int'(slot_phase) != start_phase) @(negedge clk);
        cpu_addr   = addr;
        cpu_strobe = 1'b1;
        repeat (after) @(negedge clk);
        cpu_strobe = 1'b0;
        hits = 0;
        @(negedge clk);
        repeat (8) begin
            @(negedge clk);
            if (dtack || berr || grant) hits++;
        end
        check(hits == 0, tag, "activity after abort", hits, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: outputs quiet during and right after reset, even with a strobe present
        cpu_strobe = 1'b1;
        cpu_addr   = A_VOID;
        repeat (4) @(negedge clk);
        check(!dtack && !berr && !grant, "R1", "outputs during reset",
              int'(dtack || berr || grant), 0);
        cpu_strobe = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!dtack && !berr && !grant, "R1", "outputs after reset",
              int'(dtack || berr || grant), 0);

        // R2: shared access started on the slot boundary
        run_access(A_RAM, 0, -1, 0, 1'b0, -1, 4, "R2");
        // R3: shared accesses started off the grid
        run_access(A_RAM, 2, -1, 0, 1'b0, 6, 4, "R3");
        run_access(A_RAM, 1, -1, 0, 1'b0, 7, 4, "R3");
        run_access(A_RAM, 3, -1, 0, 1'b0, 5, 4, "R3");
        // R4: chained accesses, landing on phase 0 and on phase 2
        run_access(A_RAM, 0, -1, 0, 1'b0, 4, 4, "R4");
        run_access(A_RAM, 2, -1, 0, 1'b0, 6, 4, "R4");
        run_access(A_RAM, 0, -1, 0, 1'b0, 4, 4, "R4");
        run_access(A_RAM, 2, -1, 0, 1'b0, 6, 4, "R4");
        // R5: local window bypasses alignment
        run_access(A_LOC, 1, 1, 0, 1'b0, 1, 0, "R5");
        run_access(A_LOC, 2, 3, 3, 1'b0, 3, 0, "R5");
        run_access(A_LOC, 3, 0, 0, 1'b0, 0, 0, "R5");
        // R6: register acknowledge during a shared access changes nothing
        run_access(A_RAM, 2, 0, 0, 1'b0, 6, 4, "R6");
        // R7: unmapped address ends in a bus error
        run_access(A_VOID, 1, -1, 3, 1'b1, ERRL, 0, "R7");
        // R8: acknowledge boundary around the timeout
        run_access(A_LOC, 0, 64, 0, 1'b0, 64, 0, "R8");
        run_access(A_LOC, 0, 65, 0, 1'b1, ERRL, 0, "R8");
        run_access(A_LOC, 2, -1, 0, 1'b1, ERRL, 0, "R8");
        // R10: aborted accesses leave nothing behind and restart the watchdog
        abort_access(A_RAM, 1, 2, "R10");
        abort_access(A_LOC, 0, 40, "R10");
        run_access(A_VOID, 0, -1, 0, 1'b1, ERRL, 0, "R10");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R9", "terminations outstanding", sb.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule